// File: doc/BRIEF.md
# Paper Tape Word Assembler and Bootstrap Loader

This block takes 8-hole lines from a paper tape reader, one line per transfer on a valid/ready stream, and turns them into 18-bit machine words. A request in character mode returns one raw line as a word. A request in word mode collects three framed lines into one word. A bootstrap mode reads the tape as a chain of instruction/data word pairs and writes the data words into memory. It stops when it reads a jump instruction and then reports the start address.

Words use big-endian bit numbering: word bit 0 is `word_out[17]`, and word bit 17 is `word_out[0]`. Hole k of a line is `line_data[k-1]`. The stream follows the valid/ready rules. A line moves on a rising edge where `line_valid` and `line_ready` are both high. `line_ready` is high only while a mode is active, so the reader is held back at all other times. A source that raises `line_valid` must keep `line_data` steady until the line is taken. The request, start and status pins are plain level or pulse signals.

Top module: `tape_loader`

## Requirements
- R1: With no mode active, `line_ready` is low and `busy` is low, and any line offered is left untaken; the next request sees only lines offered after it.
- R2: A character request (`req_alpha`) takes exactly one line and pulses `done` for one cycle with `word_out` = {10 zero bits, `line_data`}.
- R3: A word request (`req_binary`) takes three qualifying lines. Holes 1–6 (`line_data[5:0]`, hole 1 least significant) of the first, second and third lines land in `word_out[17:12]`, `word_out[11:6]` and `word_out[5:0]`, and then `done` pulses for one cycle.
- R4: In word mode and bootstrap mode, a line with hole 8 clear (`line_data[7]`=0) is taken and discarded. Hole 7 (`line_data[6]`) never affects the result.
- R5: `busy` is high from the cycle after an accepted request until its result appears. Requests made while `busy` is high are ignored.
- R6: In bootstrap mode, the words alternate instruction, data, instruction and so on, starting with an instruction. An instruction whose bits 0–4 (`word[17:13]`) equal 5'b01101 (the word begins with octal 32 or 33) is a deposit. The next word is then written with a one-cycle `mem_we` pulse, with `mem_addr` equal to the instruction's `word[11:0]`.
- R7: An instruction whose bits 0–4 equal 5'b11000 (octal 60/61) ends bootstrap mode. It pulses `start_valid` for one cycle with `start_addr` equal to its `word[11:0]`. `busy` and `line_ready` then go low.
- R8: Any other instruction code sets `load_err` and ends bootstrap mode with no memory write. `load_err` stays high until the next accepted `boot_start`.
- R9: `done` never pulses during bootstrap mode. `mem_we` and `start_valid` pulse only in bootstrap mode and never in the same cycle.
- R10: If requests arrive in the same cycle, `boot_start` takes priority over `req_binary`, and `req_binary` takes priority over `req_alpha`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_valid | input | 1 | Reader offers a line |
| line_data | input | 8 | Holes 1..8 in bits 0..7 |
| line_ready | output | 1 | Block takes the offered line this cycle |
| req_alpha | input | 1 | Start a one-line character read |
| req_binary | input | 1 | Start a three-line word read |
| boot_start | input | 1 | Start bootstrap loading |
| busy | output | 1 | A mode is active |
| done | output | 1 | One-cycle pulse: `word_out` holds a requested word |
| word_out | output | 18 | Last assembled word |
| mem_we | output | 1 | Memory write strobe (bootstrap) |
| mem_addr | output | 12 | Memory write address |
| mem_wdata | output | 18 | Memory write data |
| start_valid | output | 1 | One-cycle pulse: bootstrap ended by jump |
| start_addr | output | 12 | Jump target of the ending instruction |
| load_err | output | 1 | Bootstrap stopped on an illegal instruction |

## Verification
On every cycle, the assertions check that the result pulses last one cycle and that the group counter stays in range. They also check that an idle assembler does not move, that a memory write only follows an assembled word, and that a jump or an error really ends loading with no write in that cycle. Only the bench scenarios can show the values involved. These are the bit placement of the three groups, the skipping of unframed lines, the pairing of each data word with its deposit address, the jump target, the priority of simultaneous requests, and the ignoring of requests while busy.

// File: rtl/tl_pkg.sv
package tl_pkg;
  localparam int LINE_W  = 8;
  localparam int GROUP_W = 6;
  localparam int GROUPS  = 3;
  localparam int WORD_W  = GROUP_W * GROUPS;
  localparam int ADDR_W  = 12;
  localparam int OP_W    = 5;
  localparam logic [OP_W-1:0] OP_DEPOSIT = 5'b01101;
  localparam logic [OP_W-1:0] OP_JUMP    = 5'b11000;
endpackage

// File: rtl/tl_packer.sv
module tl_packer #(
  parameter int LINE_W  = tl_pkg::LINE_W,
  parameter int GROUP_W = tl_pkg::GROUP_W,
  parameter int GROUPS  = tl_pkg::GROUPS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        arm,
  input  logic                        arm_alpha,
  input  logic                        line_valid,
  input  logic [LINE_W-1:0]           line_data,
  output logic                        line_ready,
  output logic                        active,
  output logic                        word_valid,
  output logic [GROUP_W*GROUPS-1:0]   word
);
  localparam int WORD_W    = GROUP_W * GROUPS;
  localparam int CNT_W     = $clog2(GROUPS + 1);
  localparam int FRAME_BIT = LINE_W - 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUPS - 1);

  logic              alpha_r;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] next_acc;
  logic              take;

  assign line_ready = active;
  assign take       = line_valid && active;
  assign next_acc   = (acc << GROUP_W) | WORD_W'(line_data[GROUP_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      alpha_r    <= 1'b0;
      cnt        <= '0;
      acc        <= '0;
      word       <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (arm && !active) begin
        active  <= 1'b1;
        alpha_r <= arm_alpha;
        cnt     <= '0;
        acc     <= '0;
      end else if (take) begin
        if (alpha_r) begin
          word       <= WORD_W'(line_data);
          word_valid <= 1'b1;
          active     <= 1'b0;
        end else if (line_data[FRAME_BIT]) begin
          if (cnt == LAST) begin
            word       <= next_acc;
            word_valid <= 1'b1;
            active     <= 1'b0;
          end else begin
            acc <= next_acc;
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid); // R2
  AST_GROUP_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R3
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !arm) |=> ($stable(cnt) && !word_valid)); // R1
  AST_RESULT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !active); // R5
endmodule

// File: rtl/tl_boot_seq.sv
module tl_boot_seq #(
  parameter int WORD_W = tl_pkg::WORD_W,
  parameter int ADDR_W = tl_pkg::ADDR_W,
  parameter int OP_W   = tl_pkg::OP_W,
  parameter logic [OP_W-1:0] OP_DEP = tl_pkg::OP_DEPOSIT,
  parameter logic [OP_W-1:0] OP_JMP = tl_pkg::OP_JUMP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pk_active,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word,
  output logic              boot_active,
  output logic              boot_arm,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              start_valid,
  output logic [ADDR_W-1:0] start_addr,
  output logic              load_err
);
  typedef enum logic { PH_INSTR, PH_DATA } phase_e;

  phase_e            phase;
  logic [ADDR_W-1:0] dep_addr;
  logic [OP_W-1:0]   op;
  logic [ADDR_W-1:0] target;

  assign op       = word[WORD_W-1 -: OP_W];
  assign target   = word[ADDR_W-1:0];
  assign boot_arm = boot_active && !pk_active && !word_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_active <= 1'b0;
      phase       <= PH_INSTR;
      dep_addr    <= '0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      start_valid <= 1'b0;
      start_addr  <= '0;
      load_err    <= 1'b0;
    end else begin
      mem_we      <= 1'b0;
      start_valid <= 1'b0;
      if (start) begin
        boot_active <= 1'b1;
        phase       <= PH_INSTR;
        load_err    <= 1'b0;
      end else if (boot_active && word_valid) begin
        if (phase == PH_INSTR) begin
          if (op == OP_DEP) begin
            dep_addr <= target;
            phase    <= PH_DATA;
          end else if (op == OP_JMP) begin
            start_valid <= 1'b1;
            start_addr  <= target;
            boot_active <= 1'b0;
          end else begin
            load_err    <= 1'b1;
            boot_active <= 1'b0;
          end
        end else begin
          mem_we    <= 1'b1;
          mem_addr  <= dep_addr;
          mem_wdata <= word;
          phase     <= PH_INSTR;
        end
      end
    end
  end

  AST_WRITE_FOLLOWS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(word_valid && boot_active)); // R6
  AST_JUMP_ENDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |-> (!boot_active && !mem_we)); // R7
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_err) |-> (!mem_we && !boot_active)); // R8
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_err && !start) |=> load_err); // R8
endmodule

// File: rtl/tape_loader.sv
module tape_loader #(
  parameter int LINE_W  = tl_pkg::LINE_W,
  parameter int GROUP_W = tl_pkg::GROUP_W,
  parameter int GROUPS  = tl_pkg::GROUPS,
  parameter int ADDR_W  = tl_pkg::ADDR_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      line_valid,
  input  logic [LINE_W-1:0]         line_data,
  output logic                      line_ready,
  input  logic                      req_alpha,
  input  logic                      req_binary,
  input  logic                      boot_start,
  output logic                      busy,
  output logic                      done,
  output logic [GROUP_W*GROUPS-1:0] word_out,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [GROUP_W*GROUPS-1:0] mem_wdata,
  output logic                      start_valid,
  output logic [ADDR_W-1:0]         start_addr,
  output logic                      load_err
);
  localparam int WORD_W = GROUP_W * GROUPS;

  logic              pk_active, pk_valid, pk_arm, pk_alpha;
  logic              boot_active, boot_arm, boot_go, user_go;
  logic [WORD_W-1:0] pk_word;

  assign busy     = pk_active || boot_active;
  assign boot_go  = boot_start && !busy;
  assign user_go  = !busy && !boot_start && (req_binary || req_alpha);
  assign pk_arm   = boot_arm || user_go;
  assign pk_alpha = !boot_active && !req_binary && req_alpha;
  assign done     = pk_valid && !boot_active;
  assign word_out = pk_word;

  tl_packer #(.LINE_W(LINE_W), .GROUP_W(GROUP_W), .GROUPS(GROUPS)) u_packer (
    .clk(clk), .rst_n(rst_n), .arm(pk_arm), .arm_alpha(pk_alpha),
    .line_valid(line_valid), .line_data(line_data), .line_ready(line_ready),
    .active(pk_active), .word_valid(pk_valid), .word(pk_word)
  );

  tl_boot_seq #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_boot (
    .clk(clk), .rst_n(rst_n), .start(boot_go), .pk_active(pk_active),
    .word_valid(pk_valid), .word(pk_word), .boot_active(boot_active),
    .boot_arm(boot_arm), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .start_valid(start_valid),
    .start_addr(start_addr), .load_err(load_err)
  );

  AST_DONE_OUTSIDE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_we && !start_valid)); // R9
  AST_WRITE_START_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && start_valid)); // R9
  AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_ready); // R1
endmodule

// File: tb/test_tape_loader.sv
module test_tape_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_valid = 1'b0;
  logic [7:0]  line_data = '0;
  logic        line_ready;
  logic        req_alpha = 1'b0, req_binary = 1'b0, boot_start = 1'b0;
  logic        busy, done, mem_we, start_valid, load_err;
  logic [17:0] word_out, mem_wdata;
  logic [11:0] mem_addr, start_addr;

  int checks = 0, errors = 0;
  bit finished = 0;

  int          wr_n = 0, sv_n = 0, done_n = 0;
  logic [11:0] wr_addr [64];
  logic [17:0] wr_data [64];
  logic [11:0] sv_addr;

  always #10 clk = ~clk;

  tape_loader i_tape_loader (
    .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_data(line_data),
    .line_ready(line_ready), .req_alpha(req_alpha), .req_binary(req_binary),
    .boot_start(boot_start), .busy(busy), .done(done), .word_out(word_out),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .start_valid(start_valid), .start_addr(start_addr), .load_err(load_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we && wr_n < 64) begin wr_addr[wr_n] = mem_addr; wr_data[wr_n] = mem_wdata; wr_n++; end
      if (start_valid) begin sv_n++; sv_addr = start_addr; end
      if (done) done_n++;
    end
  end

  function automatic logic [17:0] pack3(input logic [7:0] a, b, c);
    return {a[5:0], b[5:0], c[5:0]};
  endfunction

  function automatic logic [7:0] frame(input logic [5:0] g);
    return {1'b1, 1'($urandom), g};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic request(input logic a, input logic b, input logic s);
    @(negedge clk);
    req_alpha = a; req_binary = b; boot_start = s;
    @(negedge clk);
    req_alpha = 0; req_binary = 0; boot_start = 0;
  endtask

  task automatic send_line(input logic [7:0] d);
    line_valid = 1'b1; line_data = d;
    while (!line_ready) @(negedge clk);
    @(posedge clk); #1;
    line_valid = 1'b0; line_data = 8'($urandom);
    @(negedge clk);
  endtask

  task automatic junk();
    if ($urandom_range(0, 1) == 1) send_line({1'b0, 7'($urandom)});
  endtask

  task automatic send_word(input logic [17:0] w);
    junk(); send_line(frame(w[17:12]));
    junk(); send_line(frame(w[11:6]));
    junk(); send_line(frame(w[5:0]));
  endtask

  task automatic wait_done(output logic [17:0] w, output bit seen);
    int n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    seen = done; w = word_out;
    @(negedge clk);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [17:0] w, exp;
    logic [7:0]  l0, l1, l2;
    bit          seen;
    int          d0, wbase;
    void'($urandom(32'd1960));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    check(!busy && !line_ready && !done && !mem_we && !start_valid && !load_err,
          "R1 reset", {busy, line_ready, done, mem_we, start_valid, load_err}, 0);

    // R1: line offered while idle is not taken
    line_valid = 1'b1; line_data = 8'hA5;
    settle(5);
    check(!line_ready && !busy, "R1 idle hold", line_ready, 0);
    line_valid = 1'b0;
    request(1, 0, 0);
    send_line(8'h3C);
    wait_done(w, seen);
    check(seen && w == 18'h0003C, "R1 fresh line only", w, 18'h3C);

    // R2: character mode, random lines
    for (int i = 0; i < 8; i++) begin
      l0 = 8'($urandom);
      request(1, 0, 0);
      check(busy, "R5 busy after request", busy, 1);
      send_line(l0);
      wait_done(w, seen);
      check(seen && w == {10'b0, l0}, "R2 char word", w, {10'b0, l0});
      check(!busy, "R5 busy clears", busy, 0);
    end

    // R3/R4: word mode with skipped unframed lines
    for (int i = 0; i < 8; i++) begin
      l0 = frame(6'($urandom)); l1 = frame(6'($urandom)); l2 = frame(6'($urandom));
      request(0, 1, 0);
      junk(); send_line(l0); junk(); send_line(l1); junk(); send_line(l2);
      wait_done(w, seen);
      exp = pack3(l0, l1, l2);
      check(seen && w == exp, "R3 R4 word assembly", w, exp);
    end

    // R4: hole 7 ignored, directed
    request(0, 1, 0);
    send_line(8'hC1); send_line(8'h7F); send_line(8'h82); send_line(8'hFF);
    wait_done(w, seen);
    check(seen && w == 18'o010277, "R4 hole7 and skip", w, 18'o010277);

    // R5: request during busy ignored
    request(0, 1, 0);
    send_line(8'h81);
    request(1, 0, 0);
    check(busy && done_n >= 0, "R5 still busy", busy, 1);
    d0 = done_n;
    send_line(8'h82);
    settle(2);
    check(done_n == d0, "R5 alpha ignored while busy", done_n - d0, 0);
    send_line(8'h83);
    wait_done(w, seen);
    check(seen && w == 18'o010203, "R5 binary kept", w, 18'o010203);

    // R10: binary beats alpha
    request(1, 1, 0);
    send_line(8'h85);
    settle(2);
    check(busy, "R10 binary over alpha", busy, 1);
    send_line(8'h86); send_line(8'h87);
    wait_done(w, seen);
    check(seen && w == 18'o050607, "R10 binary word", w, 18'o050607);

    // R6/R7/R9: bootstrap with random deposits
    wbase = wr_n; d0 = done_n;
    request(0, 0, 1);
    for (int i = 0; i < 5; i++) begin
      logic [11:0] a = 12'($urandom);
      logic [17:0] dv = 18'($urandom);
      send_word({6'o32 | 6'($urandom_range(0, 1)), a});
      send_word(dv);
      settle(2);
      check(wr_n == wbase + i + 1, "R6 write count", wr_n, wbase + i + 1);
      if (wr_n == wbase + i + 1) begin
        check(wr_addr[wbase + i] == a, "R6 write addr", wr_addr[wbase + i], a);
        check(wr_data[wbase + i] == dv, "R6 write data", wr_data[wbase + i], dv);
      end
    end
    check(busy, "R6 still loading", busy, 1);
    send_word({6'o60, 12'o7421});
    settle(3);
    check(sv_n == 1 && sv_addr == 12'o7421, "R7 start address", sv_addr, 12'o7421);
    check(!busy && !line_ready, "R7 load ended", {busy, line_ready}, 0);
    check(done_n == d0, "R9 no done in load", done_n - d0, 0);
    check(!load_err, "R8 no error on clean load", load_err, 0);

    // R8: illegal instruction
    wbase = wr_n;
    request(0, 0, 1);
    send_word({6'o20, 12'o0100});
    settle(3);
    check(load_err && !busy, "R8 error stops load", {load_err, busy}, 2);
    line_valid = 1'b1; line_data = 8'hFF;
    settle(4);
    check(!line_ready, "R8 no lines after error", line_ready, 0);
    line_valid = 1'b0;
    settle(3);
    check(load_err && wr_n == wbase, "R8 error holds, no write", {load_err, 8'(wr_n - wbase)}, 9'h100);

    // R10: boot beats binary; error cleared by new start
    d0 = done_n;
    request(0, 1, 1);
    check(!load_err, "R8 error cleared on start", load_err, 1'b0);
    send_word({6'o61, 12'o0042});
    settle(3);
    check(sv_n == 2 && sv_addr == 12'o0042 && done_n == d0, "R10 boot over binary", sv_addr, 12'o0042);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule